// File: doc/BRIEF.md
# Microprogrammed Rising-Edge Detector

This block detects rising edges on a single-bit input by running a fixed eight-word microprogram. It does not use a hardwired next-state table. A program counter addresses a small constant store. Each fetched word does one of two things. It either writes a registered output bit, or it performs a conditional jump that tests the input at a chosen polarity. The result behaves as a Moore machine: the output comes from a register and changes only when an output word executes.

The controller clock runs twice as fast as the input can change, and the two are aligned. The input therefore stays stable for at least two controller cycles. That is exactly long enough for the program to step through an output word and then a test word. A rising edge produces a pulse on the output that is two controller cycles wide. While the input stays high afterwards, the program parks in a two-word loop and holds the output low. Input synchronization is left to the surrounding logic.

Top module: `edge_microseq`

## Requirements
- R1: A microword whose bit 7 is 0 is an output word: on the next clock edge, bit 0 of the word is copied into `dout`.
- R2: `dout` keeps its value on every clock edge at which a jump word (bit 7 = 1) executes.
- R3: A jump word with bit 6 = 1 loads the counter with the word's target field (bits 2:0) when `din` is 0. A jump word with bit 6 = 0 loads the target when `din` is 1.
- R4: When a jump is not taken, and after every output word, the counter advances by one and wraps from 7 to 0.
- R5: The stored program is as follows. Addresses 0, 4 and 6 output 0, and address 2 outputs 1. Addresses 1, 3 and 5 jump to 0 when `din` is low. Address 7 jumps to 6 when `din` is high.
- R6: A synchronous reset sets the counter to 0 and `dout` to 0.
- R7: With `din` held for two-cycle periods, each low-to-high transition of `din` raises `dout` for exactly two consecutive cycles. `dout` stays low for as long as `din` then stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 1 | Already-synchronized input to watch, stable for two cycles |
| dout | output | 1 | Registered edge-detect pulse |

## Verification
The interesting coincidence in this block is a taken jump landing on an output word while `din` changes in that same cycle. The case that matters most is a wrap from address 7 to address 0 on the cycle in which `din` falls. Another is a release from the high-hold loop on exactly the cycle in which a new low period starts. Random two-cycle input patterns produce these alignments many times, and directed runs force both phase alignments of `din` relative to the program. A cycle-level reference model built from the program listing judges `dout` on every cycle. Separate pulse-width and hold checks judge the edge behaviour.

// File: rtl/edge_microseq.sv
module edge_microseq #(
  parameter int PC_W   = 3,
  parameter int WORD_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);

  localparam int OP_BIT  = WORD_W - 1;
  localparam int POL_BIT = WORD_W - 2;

  function automatic logic [WORD_W-1:0] prog(input logic [PC_W-1:0] a);
    logic [WORD_W-1:0] w;
    w = '0;
    case (int'(a))
      0, 4, 6: w = '0;
      2:       w[0] = 1'b1;
      1, 3, 5: begin w[OP_BIT] = 1'b1; w[POL_BIT] = 1'b1; end
      7:       begin w[OP_BIT] = 1'b1; w[PC_W-1:0] = PC_W'(6); end
      default: w = '0;
    endcase
    return w;
  endfunction

  logic [PC_W-1:0]   pc;
  logic [WORD_W-1:0] word;
  logic              is_jmp;
  logic              taken;
  logic [PC_W-1:0]   pc_nxt;
  logic              unused_bits;

  assign word        = prog(pc);
  assign is_jmp      = word[OP_BIT];
  assign taken       = is_jmp & (din ^ word[POL_BIT]);
  assign pc_nxt      = taken ? word[PC_W-1:0] : pc + 1'b1;
  assign unused_bits = ^word;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc   <= '0;
      dout <= 1'b0;
    end else begin
      pc <= pc_nxt;
      if (!is_jmp) dout <= word[0];
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (pc == '0 && !dout)); // R6
  AST_JUMP_KEEPS_OUT: assert property (@(posedge clk) disable iff (rst) is_jmp |=> $stable(dout)); // R2
  AST_TARGET_LOADED: assert property (@(posedge clk) disable iff (rst)
    (is_jmp && (din != word[POL_BIT])) |=> pc == $past(word[PC_W-1:0])); // R3
  AST_SEQUENTIAL_STEP: assert property (@(posedge clk) disable iff (rst)
    !(is_jmp && (din != word[POL_BIT])) |=> pc == PC_W'($past(pc) + 1'b1)); // R4
  AST_HIGH_PARK: assert property (@(posedge clk) disable iff (rst)
    (pc == PC_W'(7) && din) |=> (pc == PC_W'(6))); // R5
  AST_PULSE_SET: assert property (@(posedge clk) disable iff (rst)
    (pc == PC_W'(2)) |=> dout); // R1

endmodule

// File: tb/test_edge_microseq.sv
module test_edge_microseq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic din = 1'b0;
  logic dout;

  int checks = 0;
  int failures = 0;
  int m_pc = 0;
  logic m_out = 1'b0;
  string m_tag = "R6";
  bit done = 0;

  edge_microseq i_edge_microseq (.clk(clk), .rst(rst), .din(din), .dout(dout));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s at %0t: dout=%0b expected=%0b", tag, $time, act, exp);
    end
  endtask

  // Reference from the listed program: returns next pc, updates output
  task automatic model_step(input logic d);
    case (m_pc)
      0, 4, 6: begin m_out = 1'b0; m_pc = (m_pc + 1) % 8; m_tag = "R1"; end
      2:       begin m_out = 1'b1; m_pc = 3; m_tag = "R1"; end
      1, 3, 5: if (!d) begin m_pc = 0; m_tag = "R3"; end
               else begin m_pc = m_pc + 1; m_tag = "R4"; end
      default: if (d) begin m_pc = 6; m_tag = "R3"; end
               else begin m_pc = 0; m_tag = "R4"; end
    endcase
  endtask

  // one cycle: drive value for next edge, then compare after it
  task automatic cycle(input logic d);
    din = d;
    model_step(d);
    @(negedge clk);
    check(m_tag, dout, m_out);
  endtask

  task automatic hold(input logic d, input int periods);
    for (int i = 0; i < periods; i++) begin
      cycle(d);
      cycle(d);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    m_pc = 0; m_out = 1'b0;
    check("R6", dout, 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    int hi_run;
    int max_run;
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();

    hold(1'b0, 6);
    check("R5", dout, 1'b0);

    // Single rising edge, then long high: pulse width and parking
    hi_run = 0; max_run = 0;
    for (int i = 0; i < 20; i++) begin
      cycle(1'b1);
      if (dout) hi_run++;
    end
    check("R7", logic'(hi_run == 2), 1'b1);
    check("R5", dout, 1'b0);
    hold(1'b0, 3);

    // Edge at the other phase alignment
    cycle(1'b0);
    hi_run = 0;
    for (int i = 0; i < 12; i++) begin
      cycle(1'b1);
      if (dout) hi_run++;
    end
    check("R7", logic'(hi_run == 2), 1'b1);
    cycle(1'b0);
    cycle(1'b0);

    // Alternating pattern exercises wrap and taken jumps
    for (int i = 0; i < 10; i++) begin
      hold(1'b1, 1);
      hold(1'b0, 1);
    end

    // Random two-cycle input with a pulse width check
    hi_run = 0;
    for (int i = 0; i < 2000; i++) begin
      logic b;
      b = logic'($urandom_range(0, 1));
      hold(b, 1);
      if (dout) hi_run++;
      else begin
        if (hi_run > max_run) max_run = hi_run;
        hi_run = 0;
      end
    end
    check("R7", logic'(max_run <= 2), 1'b1);

    // Reset mid-pulse
    cycle(1'b0); cycle(1'b0);
    cycle(1'b1);
    do_reset();
    hold(1'b0, 2);
    check("R6", dout, 1'b0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired: actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule